// File: doc/BRIEF.md
# Dual-Issue Pair Checker

This block sits at the issue stage of a two-way in-order superscalar pipeline. Each cycle the fetch stage hands it one decoded two-instruction packet: the left slot carries an integer-class instruction (ALU, branch, integer or FP load/store, or an FP operation that ended up on the left), and the right slot carries at most one FP operation. Decoding happens upstream. The block receives each slot's kind and register indices and decides, in the same cycle, whether the left instruction, the right instruction, both or neither may issue.

Issue follows fixed pairing rules on top of data dependences. The right instruction never goes ahead of the left one. An issue group holds at most one FP operation. A load in the left slot cannot feed its partner in the same packet, nor either instruction of the packet that follows it. The block keeps two pieces of state. One is the destination of a load issued in the previous cycle. The other is a flag recording that the left half of a held packet has already left, so that the right half can be offered alone on the next cycle.

When `stall` is high, the fetch stage must present the same packet again on the next cycle.

Top module: `pair_issue_gate`

## Requirements
- R1: After reset no load is in flight and the left-done flag is clear, so the first valid packet issues with no dependence stall. While `pkt_valid` is low, all three outputs are 0.
- R2: A cycle with `pkt_valid` low issues nothing and records no load, even if the slot fields describe a load. An instruction that reads that load's destination on the next cycle issues at once.
- R3: An independent pair issues in one cycle (`issue_l`=1, `issue_r`=1, `stall`=0). Left kind encodings: 0 empty, 1 ALU (reads int A and B, writes int), 2 branch (reads int A only), 3 integer load (reads int A, writes int), 4 integer store (reads int A and B), 5 FP load (reads int A, writes FP), 6 FP store (reads int A, reads FP B), 7 FP operation (reads FP A and B, writes FP).
- R4: If the left instruction has a hazard, neither slot issues and `stall` is 1. The right instruction issues only in the same cycle as the left, or after the left half has already issued, or when the left slot is empty.
- R5: A left FP operation (kind 7) and a right FP operation never issue together. The left issues with `stall`=1, and on the re-presented packet the right issues alone with `stall`=0.
- R6: A right instruction that reads the FP destination of a left kind 5 or 7 in the same packet, or that writes that same FP destination, does not pair. Only the left issues.
- R7: A load (kind 3 or 5) issued in cycle t blocks, in cycle t+1, any instruction that reads its destination in the same register file. Only the sources the kind actually reads are compared. A register of the other file with the same index does not block.
- R8: An FP load or FP store in the left slot pairs with a right FP operation when no register dependence exists.
- R9: Once the left half of a held packet has issued, it never issues again. `stall` stays 1 until the right half has issued.
- R10: With an empty left slot (kind 0), a valid right instruction issues alone, subject only to its own hazards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| l_kind | input | 3 | Left-slot instruction kind (encoding in R3) |
| l_dst | input | REG_W | Left destination register index |
| l_src_a | input | REG_W | Left source A register index |
| l_src_b | input | REG_W | Left source B register index |
| r_valid | input | 1 | Right slot holds an FP operation |
| r_dst | input | REG_W | Right FP destination index |
| r_src_a | input | REG_W | Right FP source A index |
| r_src_b | input | REG_W | Right FP source B index |
| issue_l | output | 1 | Left instruction issues this cycle |
| issue_r | output | 1 | Right instruction issues this cycle |
| stall | output | 1 | Packet not finished; present it again next cycle |

## Verification
All three outputs are combinational and are due in the same cycle the packet is presented. The in-flight load record and the left-done flag only affect the cycle after the edge that captures them. The bench drives inputs on the falling edge and compares one time unit later, so every comparison sees the current packet together with state updated by exactly the edges before it. Multi-cycle cases (load-use, held right half) are checked cycle by cycle against a bench-side rule model that runs alongside the directed cases and a long sweep with deliberately colliding register indices.

// File: rtl/dip_pkg.sv
// Shared types for the dual-issue pair checker.
// Assumes a 3-bit left-slot kind code; the right slot is always an FP operation.
package dip_pkg;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_ALU    = 3'd1,
        K_BRANCH = 3'd2,
        K_LOAD   = 3'd3,
        K_STORE  = 3'd4,
        K_FLOAD  = 3'd5,
        K_FSTORE = 3'd6,
        K_FPOP   = 3'd7
    } lkind_e;

    // Register-file usage of one left-slot instruction.
    typedef struct packed {
        logic present;   // slot holds an instruction
        logic rd_a_int;  // source A from integer file
        logic rd_a_fp;   // source A from FP file
        logic rd_b_int;  // source B from integer file
        logic rd_b_fp;   // source B from FP file
        logic wr_int;    // writes integer file
        logic wr_fp;     // writes FP file
        logic is_load;   // result arrives late (load)
        logic fpu;       // occupies the FP operation unit
    } usage_t;

endpackage

// File: rtl/dip_lane_decode.sv
// Left-slot usage decoder.
// Turns a kind code into the register files it reads and writes and the unit it
// occupies. Purely combinational; unknown codes cannot occur (all 8 are defined).
module dip_lane_decode
    import dip_pkg::*;
(
    input  lkind_e kind,
    output usage_t use_o
);

    // Map each kind onto its read/write/unit flags.
    always_comb begin
        use_o = '0;
        case (kind)
            K_ALU: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
                use_o.rd_b_int = 1'b1;
                use_o.wr_int   = 1'b1;
            end
            K_BRANCH: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
            end
            K_LOAD: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
                use_o.wr_int   = 1'b1;
                use_o.is_load  = 1'b1;
            end
            K_STORE: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
                use_o.rd_b_int = 1'b1;
            end
            K_FLOAD: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
                use_o.wr_fp    = 1'b1;
                use_o.is_load  = 1'b1;
            end
            K_FSTORE: begin
                use_o.present  = 1'b1;
                use_o.rd_a_int = 1'b1;
                use_o.rd_b_fp  = 1'b1;
            end
            K_FPOP: begin
                use_o.present  = 1'b1;
                use_o.rd_a_fp  = 1'b1;
                use_o.rd_b_fp  = 1'b1;
                use_o.wr_fp    = 1'b1;
                use_o.fpu      = 1'b1;
            end
            default: use_o = '0;
        endcase
    end

endmodule

// File: rtl/dip_load_tracker.sv
// One-cycle record of a load issued from the left slot.
// Holds the destination and its register file for exactly the cycle after the
// load issues; any other cycle the record is invalid. Synchronous active-low reset.
module dip_load_tracker #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             cap_fp,
    input  logic [REG_W-1:0] cap_dst,
    output logic             ld_valid,
    output logic             ld_fp,
    output logic [REG_W-1:0] ld_dst
);

    // Latch the load issued this cycle, or clear the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_fp    <= 1'b0;
            ld_dst   <= '0;
        end else begin
            ld_valid <= capture;
            ld_fp    <= cap_fp;
            ld_dst   <= cap_dst;
        end
    end

endmodule

// File: rtl/dip_pair_arbiter.sv
// Combinational issue decision for one packet.
// Applies the load-use check to both slots, the one-FP-operation and
// same-packet dependence rules to the pair, and in-order pairing.
// Assumes left_done means the left half of this packet issued earlier.
module dip_pair_arbiter
    import dip_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             pkt_valid,
    input  logic             left_done,
    input  usage_t           l_use,
    input  logic [REG_W-1:0] l_dst,
    input  logic [REG_W-1:0] l_src_a,
    input  logic [REG_W-1:0] l_src_b,
    input  logic             r_valid,
    input  logic [REG_W-1:0] r_dst,
    input  logic [REG_W-1:0] r_src_a,
    input  logic [REG_W-1:0] r_src_b,
    input  logic             ld_valid,
    input  logic             ld_fp,
    input  logic [REG_W-1:0] ld_dst,
    output logic             issue_l,
    output logic             issue_r,
    output logic             left_clear,
    output logic             stall
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_W-1:0] l_srcs;
    logic [NSRC-1:0]            rd_int;
    logic [NSRC-1:0]            rd_fp;
    logic [NSRC-1:0]            src_hit;
    logic                       l_hazard;
    logic                       r_hazard;
    logic                       pair_block;

    assign l_srcs = {l_src_b, l_src_a};
    assign rd_int = {l_use.rd_b_int, l_use.rd_a_int};
    assign rd_fp  = {l_use.rd_b_fp,  l_use.rd_a_fp};

    // One load-use comparator per left source, matched on index and file.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_hit[s] = ld_valid && (l_srcs[s] == ld_dst) &&
                            ((rd_int[s] && !ld_fp) || (rd_fp[s] && ld_fp));
    end

    // Hazard terms and the final issue decision.
    always_comb begin
        l_hazard   = |src_hit;
        r_hazard   = ld_valid && ld_fp &&
                     ((r_src_a == ld_dst) || (r_src_b == ld_dst));
        pair_block = !left_done && l_use.present &&
                     (l_use.fpu ||
                      (l_use.wr_fp && ((r_src_a == l_dst) ||
                                       (r_src_b == l_dst) ||
                                       (r_dst   == l_dst))));
        issue_l    = pkt_valid && !left_done && l_use.present && !l_hazard;
        left_clear = left_done || !l_use.present || issue_l;
        issue_r    = pkt_valid && r_valid && left_clear && !r_hazard && !pair_block;
        stall      = pkt_valid && !(left_clear && (!r_valid || issue_r));
    end

endmodule

// File: rtl/pair_issue_gate.sv
// Dual-issue pair checker, top level.
// Decides per cycle which halves of a two-instruction packet issue. Assumes
// the fetch stage re-presents the same packet whenever stall is high.
// Synchronous active-low reset.
module pair_issue_gate
    import dip_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [2:0]       l_kind,
    input  logic [REG_W-1:0] l_dst,
    input  logic [REG_W-1:0] l_src_a,
    input  logic [REG_W-1:0] l_src_b,
    input  logic             r_valid,
    input  logic [REG_W-1:0] r_dst,
    input  logic [REG_W-1:0] r_src_a,
    input  logic [REG_W-1:0] r_src_b,
    output logic             issue_l,
    output logic             issue_r,
    output logic             stall
);

    usage_t           l_use;
    logic             left_done;
    logic             left_clear;
    logic             ld_valid;
    logic             ld_fp;
    logic [REG_W-1:0] ld_dst;

    dip_lane_decode u_dec (
        .kind  (lkind_e'(l_kind)),
        .use_o (l_use)
    );

    dip_load_tracker #(.REG_W(REG_W)) u_ld (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (issue_l && l_use.is_load),
        .cap_fp   (l_use.wr_fp),
        .cap_dst  (l_dst),
        .ld_valid (ld_valid),
        .ld_fp    (ld_fp),
        .ld_dst   (ld_dst)
    );

    dip_pair_arbiter #(.REG_W(REG_W)) u_arb (
        .pkt_valid  (pkt_valid),
        .left_done  (left_done),
        .l_use      (l_use),
        .l_dst      (l_dst),
        .l_src_a    (l_src_a),
        .l_src_b    (l_src_b),
        .r_valid    (r_valid),
        .r_dst      (r_dst),
        .r_src_a    (r_src_a),
        .r_src_b    (r_src_b),
        .ld_valid   (ld_valid),
        .ld_fp      (ld_fp),
        .ld_dst     (ld_dst),
        .issue_l    (issue_l),
        .issue_r    (issue_r),
        .left_clear (left_clear),
        .stall      (stall)
    );

    // Remember that the held packet's left half has already left.
    always_ff @(posedge clk) begin
        if (!rst_n) left_done <= 1'b0;
        else        left_done <= stall && left_clear;
    end

endmodule

// File: rtl/pair_issue_gate_chk.sv
// Property checker for the dual-issue pair checker, bound to every instance.
// Observes ports only.
module pair_issue_gate_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [2:0]       l_kind,
    input logic [REG_W-1:0] l_dst,
    input logic [REG_W-1:0] l_src_a,
    input logic [REG_W-1:0] l_src_b,
    input logic             r_valid,
    input logic [REG_W-1:0] r_dst,
    input logic [REG_W-1:0] r_src_a,
    input logic [REG_W-1:0] r_src_b,
    input logic             issue_l,
    input logic             issue_r,
    input logic             stall
);

    // R2: an idle cycle is quiet.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> (!issue_l && !issue_r && !stall));

    // R4: right only issues with a valid packet and a valid right slot.
    a_r4_right_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        issue_r |-> (pkt_valid && r_valid));

    // R4: a right-only issue under a present left follows a held cycle.
    a_r4_right_after_left: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_r && !issue_l && (l_kind != 3'd0)) |-> ($past(rst_n) && $past(stall)));

    // R5: never two FP operations in one group.
    a_r5_one_fpop: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_l && issue_r) |-> (l_kind != 3'd7));

    // R6: an FP load never pairs with a partner touching its destination.
    a_r6_no_pair_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_l && issue_r && (l_kind == 3'd5)) |->
        ((r_src_a != l_dst) && (r_src_b != l_dst) && (r_dst != l_dst)));

    // R7: integer load result is not read by the next cycle's ALU or store.
    a_r7_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_l) && ($past(l_kind) == 3'd3) && issue_l &&
         ((l_kind == 3'd1) || (l_kind == 3'd4))) |->
        ((l_src_a != $past(l_dst)) && (l_src_b != $past(l_dst))));

    // R9: the held packet's left half does not issue twice.
    a_r9_no_double_left: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_l && stall)) |-> !issue_l);

    // R9: a finished right half ends the stall.
    a_r9_right_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
        issue_r |-> !stall);

endmodule

bind pair_issue_gate pair_issue_gate_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/pair_issue_gate_test.sv
// Self-checking bench: directed cases plus a long sweep with colliding registers.
module pair_issue_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pkt_valid;
    logic [2:0]       l_kind;
    logic [REG_W-1:0] l_dst, l_src_a, l_src_b;
    logic             r_valid;
    logic [REG_W-1:0] r_dst, r_src_a, r_src_b;
    logic             issue_l, issue_r, stall;

    int checks = 0;
    int errors = 0;

    // Bench-side rule model state.
    bit        m_ldv;
    bit        m_ldfp;
    int        m_lddst;
    bit        m_done;
    bit        e_l, e_r, e_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_issue_gate #(.REG_W(REG_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .l_kind(l_kind),
        .l_dst(l_dst), .l_src_a(l_src_a), .l_src_b(l_src_b),
        .r_valid(r_valid), .r_dst(r_dst), .r_src_a(r_src_a), .r_src_b(r_src_b),
        .issue_l(issue_l), .issue_r(issue_r), .stall(stall)
    );

    function automatic bit rd_int_a(int k); return (k >= 1) && (k <= 6); endfunction
    function automatic bit rd_int_b(int k); return (k == 1) || (k == 4); endfunction
    function automatic bit rd_fp_a(int k);  return k == 7; endfunction
    function automatic bit rd_fp_b(int k);  return (k == 6) || (k == 7); endfunction
    function automatic bit wr_fp(int k);    return (k == 5) || (k == 7); endfunction

    task automatic chk(string tag, string what, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Expected outputs from the rules, for the inputs now applied.
    task automatic model_eval();
        int  k;
        bit  lh, rh, pb, lc;
        k  = int'(l_kind);
        lh = m_ldv && ((rd_int_a(k) && !m_ldfp && int'(l_src_a) == m_lddst) ||
                       (rd_int_b(k) && !m_ldfp && int'(l_src_b) == m_lddst) ||
                       (rd_fp_a(k)  &&  m_ldfp && int'(l_src_a) == m_lddst) ||
                       (rd_fp_b(k)  &&  m_ldfp && int'(l_src_b) == m_lddst));
        e_l = pkt_valid && !m_done && (k != 0) && !lh;
        lc  = m_done || (k == 0) || e_l;
        rh  = m_ldv && m_ldfp && (int'(r_src_a) == m_lddst || int'(r_src_b) == m_lddst);
        pb  = !m_done && (k != 0) &&
              ((k == 7) || (wr_fp(k) && (r_src_a == l_dst || r_src_b == l_dst || r_dst == l_dst)));
        e_r = pkt_valid && r_valid && lc && !rh && !pb;
        e_s = pkt_valid && !(lc && (!r_valid || e_r));
        // Next-state values, applied now; the next edge follows before the next use.
        m_ldv   = e_l && (k == 3 || k == 5);
        m_ldfp  = (k == 5);
        m_lddst = int'(l_dst);
        m_done  = e_s && lc;
    endtask

    task automatic drive(bit pv, int lk, int ld, int la, int lb, bit rv, int rd, int ra, int rb);
        @(negedge clk);
        pkt_valid = pv;
        l_kind  = 3'(lk);
        l_dst   = REG_W'(ld); l_src_a = REG_W'(la); l_src_b = REG_W'(lb);
        r_valid = rv;
        r_dst   = REG_W'(rd); r_src_a = REG_W'(ra); r_src_b = REG_W'(rb);
        #1;
        model_eval();
    endtask

    task automatic expect3(string tag, bit el, bit er, bit es);
        chk(tag, "issue_l", issue_l, el);
        chk(tag, "issue_r", issue_r, er);
        chk(tag, "stall",   stall,   es);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish (got hung, expected completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        rst_n = 1'b0;
        pkt_valid = 1'b0; l_kind = '0; l_dst = '0; l_src_a = '0; l_src_b = '0;
        r_valid = 1'b0; r_dst = '0; r_src_a = '0; r_src_b = '0;
        m_ldv = 0; m_ldfp = 0; m_lddst = 0; m_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect3("R1 reset idle", 1'b0, 1'b0, 1'b0);

        // R1: first packet after reset carries no stale hazard.
        drive(1, 1, 1, 0, 0, 1, 2, 0, 0);     expect3("R1 first packet", 1, 1, 0);

        // R2: invalid cycle with a load in its fields records nothing.
        drive(0, 3, 9, 1, 1, 1, 9, 9, 9);     expect3("R2 idle with load fields", 0, 0, 0);
        drive(1, 1, 2, 9, 9, 0, 0, 0, 0);     expect3("R2 no load captured", 1, 0, 0);

        // R3: independent ALU + FP pair.
        drive(1, 1, 1, 2, 3, 1, 4, 5, 6);     expect3("R3 independent pair", 1, 1, 0);

        // R8: FP load pairs with FP op.
        drive(1, 5, 7, 1, 0, 1, 2, 3, 4);     expect3("R8 fload+fpop", 1, 1, 0);
        // R7: FP store reading FP 7 right after the FP load is held, then issues.
        drive(1, 6, 0, 1, 7, 0, 0, 0, 0);     expect3("R7 fp load-use held", 0, 0, 1);
        drive(1, 6, 0, 1, 7, 0, 0, 0, 0);     expect3("R7 fp load-use released", 1, 0, 0);
        // R8: FP store pairs with FP op.
        drive(1, 6, 0, 1, 2, 1, 3, 4, 5);     expect3("R8 fstore+fpop", 1, 1, 0);

        // R7: integer load does not block FP register of same index.
        drive(1, 3, 3, 1, 0, 0, 0, 0, 0);     expect3("R7 int load", 1, 0, 0);
        drive(1, 1, 8, 2, 9, 1, 10, 3, 3);    expect3("R7 other file free", 1, 1, 0);
        // R4: left load-use hazard holds the whole packet.
        drive(1, 3, 4, 1, 0, 0, 0, 0, 0);     expect3("R4 int load", 1, 0, 0);
        drive(1, 1, 8, 2, 4, 1, 11, 12, 13);  expect3("R4 left hazard holds both", 0, 0, 1);
        drive(1, 1, 8, 2, 4, 1, 11, 12, 13);  expect3("R4 pair after hazard", 1, 1, 0);
        // R7: branch source B is not compared.
        drive(1, 3, 5, 1, 0, 0, 0, 0, 0);     expect3("R7 load for branch", 1, 0, 0);
        drive(1, 2, 0, 1, 5, 0, 0, 0, 0);     expect3("R7 branch B ignored", 1, 0, 0);

        // R5: two FP operations split; R9 left not repeated.
        drive(1, 7, 1, 2, 3, 1, 4, 5, 6);     expect3("R5 fpop pair split", 1, 0, 1);
        drive(1, 7, 1, 2, 3, 1, 4, 5, 6);     expect3("R9 right alone next", 0, 1, 0);

        // R6: right reads FP load destination of its partner.
        drive(1, 5, 6, 1, 0, 1, 2, 6, 3);     expect3("R6 raw in packet", 1, 0, 1);
        drive(1, 5, 6, 1, 0, 1, 2, 6, 3);     expect3("R6 raw load-use cycle", 0, 0, 1);
        drive(1, 5, 6, 1, 0, 1, 2, 6, 3);     expect3("R9 right finally issues", 0, 1, 0);
        // R6: same FP destination.
        drive(1, 5, 12, 1, 0, 1, 12, 3, 4);   expect3("R6 waw in packet", 1, 0, 1);
        drive(1, 5, 12, 1, 0, 1, 12, 3, 4);   expect3("R6 waw right next", 0, 1, 0);

        // R10: empty left slot.
        drive(1, 0, 0, 0, 0, 1, 4, 5, 6);     expect3("R10 right alone", 0, 1, 0);
        drive(1, 5, 2, 1, 0, 0, 0, 0, 0);     expect3("R10 fp load first", 1, 0, 0);
        drive(1, 0, 0, 0, 0, 1, 4, 2, 6);     expect3("R10 right hazard", 0, 0, 1);
        drive(1, 0, 0, 0, 0, 1, 4, 2, 6);     expect3("R10 right released", 0, 1, 0);

        // Sweep: every kind with small register indices so collisions are common.
        seed = 7;
        for (int p = 0; p < 3000; p++) begin
            bit pv, rv;
            int lk, ld, la, lb, rd, ra, rb, guard;
            seed = seed * 1103515245 + 12345; pv = (((seed >>> 16) & 7) != 0);
            lk   = p % 8;
            seed = seed * 1103515245 + 12345; ld = (seed >>> 16) & 3;
            seed = seed * 1103515245 + 12345; la = (seed >>> 16) & 3;
            seed = seed * 1103515245 + 12345; lb = (seed >>> 16) & 3;
            seed = seed * 1103515245 + 12345; rv = (((seed >>> 16) & 3) != 0);
            seed = seed * 1103515245 + 12345; rd = (seed >>> 16) & 3;
            seed = seed * 1103515245 + 12345; ra = (seed >>> 16) & 3;
            seed = seed * 1103515245 + 12345; rb = (seed >>> 16) & 3;
            guard = 0;
            do begin
                drive(pv, lk, ld, la, lb, rv, rd, ra, rb);
                expect3("R4 R5 R6 R7 R9 sweep", e_l, e_r, e_s);
                guard++;
            end while (e_s && guard < 6);
        end

        @(negedge clk);
        pkt_valid = 1'b0;
        #1;
        expect3("R2 final idle", 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule